// File: doc/BRIEF.md
# Per-Function Reset Completion Controller

This block sits on the application side of a PCIe endpoint that exposes several physical and several virtual functions. The endpoint core raises one reset-request bit for each function that software has ordered to reset. For each raised bit, the controller cancels the transactions still outstanding for that function. It then waits until that function's pending-transaction count reads zero and answers with a one-cycle completion pulse on the matching bit. Every function has its own state machine, so any mix of functions can be under reset at the same time without holding each other up.

The answer must arrive within a fixed time budget of 100 microseconds. The budget in cycles is derived from the clock frequency parameter, less a safety margin. If the pending work has not drained when that budget runs out, the controller forces the completion anyway and raises a sticky overrun flag for that function. While a function is anywhere in its reset sequence, its blocked bit tells the request path to accept no new transactions for it.

Top module: `fn_reset_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears every completion, cancel, blocked and overrun output to 0 on the next clock edge, and returns every function to its idle state.
- R2: Bit i of a request vector controls only bit i of the matching completion, cancel, blocked and overrun vectors. The physical and virtual groups are separate, and function i's pending count is bits [i*CNT_W +: CNT_W] of its group's count vector.
- R3: After a request is taken, the completion bit goes high one cycle after the first edge that samples that function's pending count as zero. It stays high for exactly one cycle.
- R4: After a completion, the same function gives no further completion until its request bit has been sampled low and then raised again.
- R5: The blocked bit is high from the cycle after a request is sampled high. It stays high until the cycle after the request is sampled low, once the completion has been given.
- R6: Functions are independent. Requests raised in the same cycle complete at their own times, and two functions can complete in the same cycle.
- R7: If the pending count is still non-zero, completion is forced exactly FORCE_CYC = CLK_MHZ*BUDGET_US - MARGIN_CYC cycles after the cycle in which the request was taken. The overrun bit rises in that same cycle.
- R8: If the pending count is sampled zero on the last edge of the budget, the completion is treated as clean and the overrun bit stays low.
- R9: An overrun bit stays high through later clean handshakes of that function until `rst`.
- R10: The cancel bit pulses high for exactly one cycle, in the first cycle the blocked bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_req | input | NUM_PF | Reset-request bit per physical function |
| vf_req | input | NUM_VF | Reset-request bit per virtual function |
| pf_pend | input | NUM_PF*CNT_W | Pending-transaction count per physical function |
| vf_pend | input | NUM_VF*CNT_W | Pending-transaction count per virtual function |
| pf_ack | output | NUM_PF | One-cycle completion pulse per physical function |
| vf_ack | output | NUM_VF | One-cycle completion pulse per virtual function |
| pf_cancel | output | NUM_PF | Cancel strobe per physical function |
| vf_cancel | output | NUM_VF | Cancel strobe per virtual function |
| pf_block | output | NUM_PF | New-request block per physical function |
| vf_block | output | NUM_VF | New-request block per virtual function |
| pf_ovr | output | NUM_PF | Sticky budget-overrun flag per physical function |
| vf_ovr | output | NUM_VF | Sticky budget-overrun flag per virtual function |

## Verification
The drain of a function can finish on the very edge where its budget runs out, so both the clean exit and the forced exit fall in the same cycle. The bench provokes this by holding the pending count non-zero and then releasing it just before the last budget edge on one function, and one cycle later on another. It expects the same completion cycle for both, with the overrun flag low in the first case and high in the second. It also raises several requests in one cycle so that two functions complete together, and checks both pulses against a queue of expected completions.

// File: rtl/fnrst_pkg.sv
package fnrst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_ACK   = 2'd2,
        ST_HOLD  = 2'd3
    } fn_state_e;
endpackage

// File: rtl/fnrst_fsm.sv
module fnrst_fsm
    import fnrst_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int FORCE_CYC = 19968
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [CNT_W-1:0] pend,
    output logic             ack,
    output logic             cancel,
    output logic             block,
    output logic             ovr
);
    localparam int TMR_W = $clog2(FORCE_CYC + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(FORCE_CYC - 1);

    typedef struct packed {
        fn_state_e        st;
        logic [TMR_W-1:0] tmr;
        logic             cancel;
        logic             ovr;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.cancel = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req) begin
                    r_d.st     = ST_DRAIN;
                    r_d.tmr    = '0;
                    r_d.cancel = 1'b1;
                end
            end
            ST_DRAIN: begin
                if (pend == '0) begin
                    r_d.st = ST_ACK;
                end else if (r_q.tmr == TMR_LAST) begin
                    r_d.st  = ST_ACK;
                    r_d.ovr = 1'b1;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            ST_ACK:  r_d.st = ST_HOLD;
            ST_HOLD: if (!req) r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{ST_IDLE, '0, 1'b0, 1'b0};
        else     r_q <= r_d;
    end

    assign ack    = (r_q.st == ST_ACK);
    assign block  = (r_q.st != ST_IDLE);
    assign cancel = r_q.cancel;
    assign ovr    = r_q.ovr;

    p_ack_single_r3: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    p_ack_after_drain_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> ($past(pend) == '0) || ovr);
    p_start_on_req_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(block) |-> $past(req));
    p_release_on_drop_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(block) |-> !$past(req));
    p_cancel_on_entry_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(block) |-> cancel);
    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        ovr |=> ovr);
    p_tmr_bound_r7: assert property (@(posedge clk) disable iff (rst)
        r_q.tmr <= TMR_LAST);
endmodule

// File: rtl/fnrst_bank.sv
module fnrst_bank #(
    parameter int N         = 2,
    parameter int CNT_W     = 8,
    parameter int FORCE_CYC = 19968
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0]       req,
    input  logic [N*CNT_W-1:0] pend,
    output logic [N-1:0]       ack,
    output logic [N-1:0]       cancel,
    output logic [N-1:0]       block,
    output logic [N-1:0]       ovr
);
    for (genvar g = 0; g < N; g++) begin : g_fn
        fnrst_fsm #(.CNT_W(CNT_W), .FORCE_CYC(FORCE_CYC)) u_fsm (
            .clk    (clk),
            .rst    (rst),
            .req    (req[g]),
            .pend   (pend[g*CNT_W +: CNT_W]),
            .ack    (ack[g]),
            .cancel (cancel[g]),
            .block  (block[g]),
            .ovr    (ovr[g])
        );
    end
endmodule

// File: rtl/fn_reset_ctrl.sv
module fn_reset_ctrl #(
    parameter int NUM_PF     = 2,
    parameter int NUM_VF     = 4,
    parameter int CNT_W      = 8,
    parameter int CLK_MHZ    = 200,
    parameter int BUDGET_US  = 100,
    parameter int MARGIN_CYC = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_PF-1:0]       pf_req,
    input  logic [NUM_VF-1:0]       vf_req,
    input  logic [NUM_PF*CNT_W-1:0] pf_pend,
    input  logic [NUM_VF*CNT_W-1:0] vf_pend,
    output logic [NUM_PF-1:0]       pf_ack,
    output logic [NUM_VF-1:0]       vf_ack,
    output logic [NUM_PF-1:0]       pf_cancel,
    output logic [NUM_VF-1:0]       vf_cancel,
    output logic [NUM_PF-1:0]       pf_block,
    output logic [NUM_VF-1:0]       vf_block,
    output logic [NUM_PF-1:0]       pf_ovr,
    output logic [NUM_VF-1:0]       vf_ovr
);
    localparam int BUDGET_CYC = CLK_MHZ * BUDGET_US;
    localparam int FORCE_CYC  = BUDGET_CYC - MARGIN_CYC;

    fnrst_bank #(.N(NUM_PF), .CNT_W(CNT_W), .FORCE_CYC(FORCE_CYC)) u_pf (
        .clk(clk), .rst(rst), .req(pf_req), .pend(pf_pend),
        .ack(pf_ack), .cancel(pf_cancel), .block(pf_block), .ovr(pf_ovr)
    );

    fnrst_bank #(.N(NUM_VF), .CNT_W(CNT_W), .FORCE_CYC(FORCE_CYC)) u_vf (
        .clk(clk), .rst(rst), .req(vf_req), .pend(vf_pend),
        .ack(vf_ack), .cancel(vf_cancel), .block(vf_block), .ovr(vf_ovr)
    );

    p_reset_clears_r1: assert property (@(posedge clk)
        $past(rst) |-> (pf_ack == '0) && (vf_ack == '0) && (pf_ovr == '0) && (vf_ovr == '0));
endmodule

// File: tb/tb_fn_reset_ctrl.sv
module tb_fn_reset_ctrl;
    localparam int NUM_PF = 2;
    localparam int NUM_VF = 4;
    localparam int CNT_W  = 8;
    localparam int FORCE  = 200 * 100 - 32;
    localparam int NF     = NUM_PF + NUM_VF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NUM_PF-1:0] pf_req = '0;
    logic [NUM_VF-1:0] vf_req = '0;
    logic [NUM_PF*CNT_W-1:0] pf_pend = '0;
    logic [NUM_VF*CNT_W-1:0] vf_pend = '0;
    logic [NUM_PF-1:0] pf_ack, pf_cancel, pf_block, pf_ovr;
    logic [NUM_VF-1:0] vf_ack, vf_cancel, vf_block, vf_ovr;

    always #2.5 clk = ~clk;

    fn_reset_ctrl dut (
        .clk(clk), .rst(rst), .pf_req(pf_req), .vf_req(vf_req),
        .pf_pend(pf_pend), .vf_pend(vf_pend),
        .pf_ack(pf_ack), .vf_ack(vf_ack), .pf_cancel(pf_cancel), .vf_cancel(vf_cancel),
        .pf_block(pf_block), .vf_block(vf_block), .pf_ovr(pf_ovr), .vf_ovr(vf_ovr)
    );

    typedef struct {
        int    fn;
        int    cyc;
        int    ovr;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errs = 0;
    bit   ended = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errs++;
            $display("FAIL %s got %0d exp %0d", tag, got, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(int fn, int at, int ovr, string tag);
        exp_t e;
        e.fn = fn; e.cyc = at; e.ovr = ovr; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic set_pend(int fn, int val);
        if (fn < NUM_PF) pf_pend[fn*CNT_W +: CNT_W] = CNT_W'(val);
        else             vf_pend[(fn-NUM_PF)*CNT_W +: CNT_W] = CNT_W'(val);
    endtask

    // monitor: every completion pulse is popped and compared
    always @(negedge clk) begin
        logic [NF-1:0] all_ack, all_ovr;
        exp_t e;
        all_ack = {vf_ack, pf_ack};
        all_ovr = {vf_ovr, pf_ovr};
        if (!rst) begin
            for (int i = 0; i < NF; i++) begin
                if (all_ack[i]) begin
                    if (exp_q.size() == 0) begin
                        checks++; errs++;
                        $display("FAIL R4 unexpected completion fn %0d got 1 exp 0 at %0d", i, cyc);
                    end else begin
                        e = exp_q.pop_front();
                        chk({e.tag, " function"}, i, e.fn);
                        chk({e.tag, " cycle"}, cyc, e.cyc);
                        chk({e.tag, " overrun"}, int'(all_ovr[i]), e.ovr);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            errs++; checks++;
            $display("FAIL watchdog got hung exp finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int c;
        step(3);
        // R1 reset state
        chk("R1 acks", int'({pf_ack, vf_ack}), 0);
        chk("R1 block/cancel/ovr", int'({pf_block, vf_block, pf_cancel, vf_cancel, pf_ovr, vf_ovr}), 0);
        rst = 1'b0;
        step(2);

        // R2 R3 R10: PF1 with empty pending
        c = cyc;
        pf_req[1] = 1'b1;
        push(1, c + 2, 0, "R3 pf1 clean");
        step(1);
        chk("R10 pf1 cancel", int'(pf_cancel), 2);
        chk("R5 pf1 block", int'(pf_block), 2);
        chk("R2 vf untouched", int'({vf_block, vf_cancel}), 0);
        step(1);
        chk("R10 cancel one cycle", int'(pf_cancel), 0);
        // R4: hold request, no repulse
        step(20);
        chk("R5 block held", int'(pf_block), 2);
        pf_req[1] = 1'b0;
        step(1);
        chk("R5 block after drop", int'(pf_block), 0);
        step(2);

        // R3 with pending drain on PF0
        set_pend(0, 3);
        c = cyc;
        pf_req[0] = 1'b1;
        step(6);
        chk("R3 no early ack", int'(pf_ack), 0);
        set_pend(0, 0);
        push(0, cyc + 1, 0, "R3 pf0 drained");
        step(3);
        pf_req[0] = 1'b0;
        step(2);

        // R6 parallel requests
        set_pend(NUM_PF + 1, 4);
        c = cyc;
        pf_req[0] = 1'b1;
        vf_req[1] = 1'b1;
        vf_req[2] = 1'b1;
        push(0, c + 2, 0, "R6 pf0 parallel");
        push(NUM_PF + 2, c + 2, 0, "R6 vf2 parallel");
        step(5);
        set_pend(NUM_PF + 1, 0);
        push(NUM_PF + 1, cyc + 1, 0, "R6 vf1 later");
        step(3);
        pf_req[0] = 1'b0; vf_req = '0;
        step(2);

        // R7 forced completion on VF3 and R8 collision on VF0
        set_pend(NUM_PF + 3, 5);
        set_pend(NUM_PF + 0, 5);
        c = cyc;
        vf_req[3] = 1'b1;
        vf_req[0] = 1'b1;
        push(NUM_PF + 0, c + 1 + FORCE, 0, "R8 vf0 last-edge drain");
        push(NUM_PF + 3, c + 1 + FORCE, 1, "R7 vf3 forced");
        step(FORCE);
        chk("R7 no overrun before deadline", int'(vf_ovr), 0);
        set_pend(NUM_PF + 0, 0);
        step(3);
        chk("R7 R8 overrun bits", int'(vf_ovr), 8);
        set_pend(NUM_PF + 3, 0);
        vf_req = '0;
        step(2);

        // R9 sticky across clean handshake
        c = cyc;
        vf_req[3] = 1'b1;
        push(NUM_PF + 3, c + 2, 1, "R9 vf3 sticky");
        step(4);
        vf_req[3] = 1'b0;
        step(2);
        chk("R9 still set", int'(vf_ovr), 8);
        rst = 1'b1;
        step(1);
        chk("R1 R9 reset clears overrun", int'(vf_ovr), 0);
        rst = 1'b0;
        step(3);
        chk("R3 R6 all expected seen", exp_q.size(), 0);

        ended = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule